// File: doc/BRIEF.md
# Double-Buffered Channel Configuration Bank

This block holds the configuration of one processing channel in two layers. A host writes a set of staged ("master") registers over a 16-bit parallel bus and can read them back. The datapath never sees those staged values directly. It sees a set of active ("slave") copies, and those copies change only at defined moments. The change can come from an update event, which is either a hardware update pin or a software transmit-enable strobe in the channel control word. An update copies only the fields whose bit is set in an update mask. When an immediate-update mode is on, a host write to a field reaches its active copy at once and the mask is not consulted.

The control word also carries a clear-sample-phase enable. With it set, an immediate write to the sample frequency gives a one-cycle pulse that the datapath uses to zero its sample phase accumulator. A self-clearing soft-reset strobe returns every staged and active register to zero. The channel run indication rises only after both the sample frequency and the fine interpolation phase active copies have been loaded.

Top module: `cfgb_bank`

## Requirements
- R1: A write with `host_wr`=1 stores `host_wdata` into the register at `host_addr`. `host_rdata` returns that register at any time. Address 0 is the control word: bit 15 is immediate mode, bit 14 is clear-phase enable, and bits 1 and 0 are strobes that always read 0. Address 1 holds the update mask in bits 5:0. Addresses 2..7 are fields, with field index i placed at address 7-i.
- R2: Outside immediate mode, with no update event, a write to a field changes only its staged copy. The active output keeps its value.
- R3: Writing the control word with bit 0 = 1 is a software update. At that clock edge, every field whose mask bit is set copies its staged value into its active copy. Fields whose mask bit is clear keep their active value.
- R4: The mask bits map to fields as follows: bit 5 rate divider (`div_act`), bit 4 sample frequency (`freq_act`), bit 3 fine phase (`fine_act`), bit 2 coarse phase (`coarse_act`), bit 1 routing (`route_act`), bit 0 I strobe (`istrb_act`).
- R5: The input `hw_upd` is synchronised and edge-detected. If it rises before clock edge k, the masked active copies change at edge k+2 and not before. Holding it high gives exactly one update.
- R6: With control bit 15 = 1, a write to a field updates its active copy at the same edge, whatever the mask holds.
- R7: `phase_clr` is high for exactly one cycle after an immediate write to the sample frequency while control bit 14 = 1. It stays low when bit 14 = 0 and when the write is not immediate.
- R8: Writing the control word with bit 1 = 1 zeroes every staged register, every active copy, the control bits, the mask and `run_active` at that edge.
- R9: `run_active` goes to 1 one cycle after both `freq_act` and `fine_act` have been loaded since the last reset. Loading only one of them leaves it at 0.
- R10: If a field write and an update event that selects that field fall in the same cycle, the active copy takes the newly written value.
- R11: After `rst_n` is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Staged value of the addressed register |
| hw_upd | input | 1 | Asynchronous hardware update request |
| div_act | output | 16 | Active rate divider |
| freq_act | output | 16 | Active sample frequency |
| fine_act | output | 16 | Active fine phase |
| coarse_act | output | 16 | Active coarse phase |
| route_act | output | 16 | Active routing control |
| istrb_act | output | 16 | Active I strobe setting |
| phase_clr | output | 1 | One-cycle sample-phase clear pulse |
| run_active | output | 1 | Channel may process |

## Verification
Staged writes are tried first with no update event, to show that buffering holds the active copies. Masked software updates, using two different masks, then show which fields follow their staged values and which stay put. The hardware update pin is driven in two ways. A short assertion is checked at each cycle to pin down the two-stage latency. A long held assertion, followed by a new staged value, must produce no second copy. Further cases cover a write that collides with an update, immediate writes with clear-phase enable both on and off, a non-immediate write with clear-phase enable set, and a soft reset. Together these separate mask decoding, bypass, pulse qualification and the run-start condition.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int NF = 6;

  localparam int F_ISTRB  = 0;
  localparam int F_ROUTE  = 1;
  localparam int F_COARSE = 2;
  localparam int F_FINE   = 3;
  localparam int F_FREQ   = 4;
  localparam int F_DIV    = 5;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_MASK = 3'd1;
  localparam int FIELD_TOP = NF + 1;

  localparam int C_IMM  = 15;
  localparam int C_CLR  = 14;
  localparam int C_SRST = 1;
  localparam int C_TXEN = 0;

  function automatic logic [AW-1:0] field_addr(input int idx);
    return AW'(FIELD_TOP - idx);
  endfunction

  function automatic logic [DW-1:0] ctrl_read(input logic imm, input logic clr);
    logic [DW-1:0] v;
    v = '0;
    v[C_IMM] = imm;
    v[C_CLR] = clr;
    return v;
  endfunction
endpackage

// File: rtl/cfgb_upd_sync.sv
module cfgb_upd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cfgb_field.sv
module cfgb_field #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic         upd_sel,
  input  logic         imm,
  output logic [W-1:0] master,
  output logic [W-1:0] slave
);
  logic [W-1:0] master_d;
  logic         ld;

  assign master_d = wr_hit ? wdata : master;
  assign ld       = upd_sel | (imm & wr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= '0;
      slave  <= '0;
    end else if (srst) begin
      master <= '0;
      slave  <= '0;
    end else begin
      master <= master_d;
      if (ld) slave <= master_d;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !srst) |=> $stable(slave));

  p_collide_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && wr_hit && !srst) |=> (slave == $past(wdata)));

  p_sel_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_sel && !wr_hit && !srst) |=> (slave == master));
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          mask_wr,
  input  logic          wd_imm,
  input  logic          wd_clr,
  input  logic          wd_srst,
  input  logic          wd_txen,
  input  logic [NF-1:0] wd_mask,
  input  logic          hw_rise,
  input  logic          freq_ld,
  input  logic          fine_ld,
  output logic          imm,
  output logic          clr_en,
  output logic [NF-1:0] mask,
  output logic          srst,
  output logic          upd_evt,
  output logic          run_active
);
  logic freq_done, fine_done;

  assign srst    = ctrl_wr & wd_srst;
  assign upd_evt = hw_rise | (ctrl_wr & wd_txen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm        <= 1'b0;
      clr_en     <= 1'b0;
      mask       <= '0;
      freq_done  <= 1'b0;
      fine_done  <= 1'b0;
      run_active <= 1'b0;
    end else if (srst) begin
      imm        <= 1'b0;
      clr_en     <= 1'b0;
      mask       <= '0;
      freq_done  <= 1'b0;
      fine_done  <= 1'b0;
      run_active <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        imm    <= wd_imm;
        clr_en <= wd_clr;
      end
      if (mask_wr) mask <= wd_mask;
      if (freq_ld) freq_done <= 1'b1;
      if (fine_ld) fine_done <= 1'b1;
      if (freq_done && fine_done) run_active <= 1'b1;
    end
  end

  p_srst_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!run_active && mask == '0 && !imm && !clr_en));

  p_run_needs_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_active) |-> (freq_done && fine_done));
endmodule

// File: rtl/cfgb_bank.sv
module cfgb_bank
  import cfgb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          hw_upd,
  output logic [DW-1:0] div_act,
  output logic [DW-1:0] freq_act,
  output logic [DW-1:0] fine_act,
  output logic [DW-1:0] coarse_act,
  output logic [DW-1:0] route_act,
  output logic [DW-1:0] istrb_act,
  output logic          phase_clr,
  output logic          run_active
);
  logic          hw_rise, imm, clr_en, srst, upd_evt;
  logic [NF-1:0] mask, hit;
  logic [DW-1:0] mst [NF];
  logic [DW-1:0] slv [NF];
  logic          ctrl_wr, mask_wr, freq_ld, fine_ld;

  assign ctrl_wr = host_wr && (host_addr == A_CTRL);
  assign mask_wr = host_wr && (host_addr == A_MASK);

  cfgb_upd_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hw_upd), .rise(hw_rise)
  );

  assign freq_ld = (upd_evt & mask[F_FREQ]) | (imm & hit[F_FREQ]);
  assign fine_ld = (upd_evt & mask[F_FINE]) | (imm & hit[F_FINE]);

  cfgb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .mask_wr(mask_wr),
    .wd_imm(host_wdata[C_IMM]), .wd_clr(host_wdata[C_CLR]),
    .wd_srst(host_wdata[C_SRST]), .wd_txen(host_wdata[C_TXEN]),
    .wd_mask(host_wdata[NF-1:0]),
    .hw_rise(hw_rise), .freq_ld(freq_ld), .fine_ld(fine_ld),
    .imm(imm), .clr_en(clr_en), .mask(mask), .srst(srst),
    .upd_evt(upd_evt), .run_active(run_active)
  );

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign hit[i] = host_wr && (host_addr == field_addr(i));
    cfgb_field #(.W(DW)) u_fld (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .wr_hit(hit[i]), .wdata(host_wdata),
      .upd_sel(upd_evt & mask[i]), .imm(imm),
      .master(mst[i]), .slave(slv[i])
    );
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_CTRL)      host_rdata = ctrl_read(imm, clr_en);
    else if (host_addr == A_MASK) host_rdata = DW'(mask);
    else begin
      for (int i = 0; i < NF; i++)
        if (host_addr == field_addr(i)) host_rdata = mst[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_clr <= 1'b0;
    else        phase_clr <= imm & clr_en & hit[F_FREQ] & ~srst;
  end

  assign div_act    = slv[F_DIV];
  assign freq_act   = slv[F_FREQ];
  assign fine_act   = slv[F_FINE];
  assign coarse_act = slv[F_COARSE];
  assign route_act  = slv[F_ROUTE];
  assign istrb_act  = slv[F_ISTRB];

  p_clr_with_freq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> !phase_clr);

  p_clr_loads_freq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |-> (freq_act == $past(host_wdata)));
endmodule

// File: tb/cfgb_bank_tb_top.sv
module cfgb_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        hw_upd = 1'b0;
  logic [15:0] div_act, freq_act, fine_act, coarse_act, route_act, istrb_act;
  logic        phase_clr, run_active;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  cfgb_bank dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .hw_upd(hw_upd),
    .div_act(div_act), .freq_act(freq_act), .fine_act(fine_act),
    .coarse_act(coarse_act), .route_act(route_act), .istrb_act(istrb_act),
    .phase_clr(phase_clr), .run_active(run_active)
  );

  // selector: 0..5 active field index, 6 run_active, 7 phase_clr, 8 host_rdata
  function automatic logic [15:0] observe(input int sel);
    case (sel)
      0: return istrb_act;
      1: return route_act;
      2: return coarse_act;
      3: return fine_act;
      4: return freq_act;
      5: return div_act;
      6: return {15'd0, run_active};
      7: return {15'd0, phase_clr};
      default: return host_rdata;
    endcase
  endfunction

  function automatic logic [2:0] faddr(input int idx);
    return 3'(7 - idx);
  endfunction

  task automatic expect_item(input string req, input int sel, input logic [15:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic monitor_drain();
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sb_q.pop_front();
      got = observe(it.sel);
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
      end
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    host_addr = a;
    #1;
    expect_item(req, 8, exp);
    monitor_drain();
  endtask

  task automatic expect_fields(input string req, input logic [15:0] v [6]);
    for (int i = 0; i < 6; i++) expect_item(req, i, v[i]);
  endtask

  logic [15:0] stg [6];
  logic [15:0] act [6];

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      stg[i] = '0; act[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    expect_fields("R11", act);
    expect_item("R11", 6, 16'd0);
    expect_item("R11", 7, 16'd0);
    monitor_drain();
    rst_n = 1'b1;
    @(negedge clk);

    // R1 staged writes read back; R2 actives untouched
    for (int i = 0; i < 6; i++) begin
      stg[i] = 16'h1100 + 16'(i * 16'h0111);
      hwrite(faddr(i), stg[i]);
    end
    for (int i = 0; i < 6; i++) read_check("R1", faddr(i), stg[i]);
    expect_fields("R2", act);
    monitor_drain();

    // R3 R4 software update with mask freq+coarse
    hwrite(3'd1, 16'h0014);
    read_check("R1", 3'd1, 16'h0014);
    hwrite(3'd0, 16'h0001);
    act[4] = stg[4]; act[2] = stg[2];
    expect_fields("R3_R4", act);
    expect_item("R9", 6, 16'd0);
    monitor_drain();
    read_check("R1", 3'd0, 16'h0000);

    // R5 hardware update, mask fine phase only
    hwrite(3'd1, 16'h0008);
    @(negedge clk);
    hw_upd = 1'b1;
    @(negedge clk);
    expect_item("R5", 3, 16'd0); monitor_drain();
    @(negedge clk);
    expect_item("R5", 3, 16'd0); monitor_drain();
    @(negedge clk);
    act[3] = stg[3];
    expect_fields("R5", act); monitor_drain();
    stg[3] = 16'hBEEF;
    hwrite(faddr(3), stg[3]);
    repeat (4) @(negedge clk);
    expect_item("R5", 3, act[3]); monitor_drain();
    hw_upd = 1'b0;
    repeat (4) @(negedge clk);
    expect_item("R9", 6, 16'd1); monitor_drain();

    // R4 all fields via hw update
    hwrite(3'd1, 16'h003F);
    @(negedge clk);
    hw_upd = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) act[i] = stg[i];
    expect_fields("R4", act); monitor_drain();
    hw_upd = 1'b0;
    repeat (4) @(negedge clk);

    // R10 collision of write and hw update on divider
    @(negedge clk);
    hw_upd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    host_wr = 1'b1; host_addr = faddr(5); host_wdata = 16'hC0DE;
    @(negedge clk);
    host_wr = 1'b0;
    stg[5] = 16'hC0DE; act[5] = 16'hC0DE;
    expect_fields("R10", act); monitor_drain();
    hw_upd = 1'b0;
    repeat (4) @(negedge clk);

    // R6 immediate mode, mask cleared
    hwrite(3'd1, 16'h0000);
    hwrite(3'd0, 16'h8000);
    stg[1] = 16'h0D0D; act[1] = stg[1];
    hwrite(faddr(1), stg[1]);
    expect_fields("R6", act); monitor_drain();
    // R7 immediate freq write, clear disabled
    stg[4] = 16'h0A0A; act[4] = stg[4];
    hwrite(faddr(4), stg[4]);
    expect_item("R7", 7, 16'd0);
    expect_item("R6", 4, act[4]);
    monitor_drain();
    // R7 enabled
    hwrite(3'd0, 16'hC000);
    stg[4] = 16'h0E0E; act[4] = stg[4];
    hwrite(faddr(4), stg[4]);
    expect_item("R7", 7, 16'd1);
    expect_item("R6", 4, act[4]);
    monitor_drain();
    @(negedge clk);
    expect_item("R7", 7, 16'd0); monitor_drain();
    // R7 non-immediate with clear enable: no pulse, active held (R2)
    hwrite(3'd0, 16'h4000);
    stg[4] = 16'h0F0F;
    hwrite(faddr(4), stg[4]);
    expect_item("R7", 7, 16'd0);
    expect_item("R2", 4, act[4]);
    monitor_drain();

    // R8 soft reset
    hwrite(3'd0, 16'h0002);
    for (int i = 0; i < 6; i++) begin
      stg[i] = '0; act[i] = '0;
    end
    expect_fields("R8", act);
    expect_item("R8", 6, 16'd0);
    monitor_drain();
    for (int i = 0; i < 6; i++) read_check("R8", faddr(i), 16'd0);
    read_check("R8", 3'd0, 16'd0);
    read_check("R8", 3'd1, 16'd0);

    // R9 only frequency loaded after reset: no run
    hwrite(3'd1, 16'h0010);
    stg[4] = 16'h1234;
    hwrite(faddr(4), stg[4]);
    hwrite(3'd0, 16'h0001);
    repeat (3) @(negedge clk);
    expect_item("R9", 4, 16'h1234);
    expect_item("R9", 6, 16'd0);
    monitor_drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule